// File: doc/BRIEF.md
# Serial Shift Port with Interrupt Flag

This block is a byte-wide, memory-mapped slice of a parallel/serial interface. A host reaches sixteen register slots through a 4-bit select with read and write strobes. Behind them sit an 8-bit shift register, a mode register that picks the shift direction, an interrupt flag and enable pair, and an 8-bit general port with its own direction register. The general port lets the host drive handshake lines toward a partner device.

The partner device supplies the shift clock. The block brings that clock and the serial input into its own clock domain through a two-stage synchroniser, then shifts one bit for each detected edge, most significant bit first. When eight bits have moved, a completion flag rises. If the matching enable bit is set, the interrupt request output goes high. Any host access to the shift register clears the flag and starts a new byte. The host can change the shift direction between bytes while the partner keeps clocking.

Top module: `sr_periph`

## Requirements
- R1: After reset, every register reads 0, and `irq`, `ser_out`, `pb_out` and `pb_dir` are 0.
- R2: The register slots are: index 0 general port data, 2 general port direction, 10 shift register, 11 mode register, 13 flag register, 14 enable register. Any other index reads 0, and writes to it change nothing.
- R3: Shift-in mode is selected when mode register bits 4:2 equal 3'b011 (value 0x0C). In this mode, each rising edge of the synchronised shift clock moves the synchronised serial input into bit 0 while the existing bits move toward bit 7. After eight such edges, flag bit 2 is set and the register holds the byte, first bit in bit 7.
- R4: Shift-out mode is selected when mode register bits 4:2 equal 3'b111 (value 0x1C). In this mode, each falling edge of the synchronised shift clock drives the current bit 7 onto `ser_out` and rotates the register left by one. After eight falling edges, flag bit 2 is set and the register again holds the written byte.
- R5: Once eight bits have moved, further clock edges neither shift nor count until the next shift-register access. In any other mode value, clock edges move nothing.
- R6: A read or a write of the shift register clears flag bit 2 and restarts the bit count at zero. A write also loads the register.
- R7: A write to the enable register with bit 7 at 1 sets each enable bit given as 1. With bit 7 at 0, it clears each enable bit given as 1. Enable bits given as 0 keep their value. Bit 7 of the enable register reads as 0.
- R8: `irq` is high exactly when flag bit 2 and enable bit 2 are both 1. A read of the flag register returns this value in bit 7 and the flag in bit 2.
- R9: A write to the flag register with bit 2 at 1 (for example 0x7F) clears the completion flag. The shift register contents are left unchanged.
- R10: `pb_out` and `pb_dir` show the general port data and direction registers. A read of index 0 returns, for each bit, the latched data where the direction bit is 1 and the `pb_in` pin level where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 4 | Register index |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| ext_sclk | input | 1 | Shift clock from the partner device |
| ser_in | input | 1 | Serial data from the partner device |
| ser_out | output | 1 | Serial data to the partner device |
| pb_in | input | 8 | General port pin levels |
| pb_out | output | 8 | General port output latch |
| pb_dir | output | 8 | General port direction, 1 = output |
| irq | output | 1 | Interrupt request |

## Verification
A bit counter that slips by one edge shows up on `irq` in the same cycle: the request rises one shift-clock period early or late compared with the reference model, which checks the request every clock. A wrong shift register value surfaces only when the host reads the register back, or, in shift-out mode, on `ser_out` three clock cycles after each falling edge. An enable or flag register that takes a bad value shows on `irq` and in bit 7 of the flag read on the next cycle.

// File: rtl/sr_periph.sv
module sr_periph (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_sel,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ext_sclk,
  input  logic       ser_in,
  output logic       ser_out,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_dir,
  output logic       irq
);
  localparam logic [3:0] SEL_PB   = 4'd0;
  localparam logic [3:0] SEL_DIR  = 4'd2;
  localparam logic [3:0] SEL_SR   = 4'd10;
  localparam logic [3:0] SEL_MODE = 4'd11;
  localparam logic [3:0] SEL_FLG  = 4'd13;
  localparam logic [3:0] SEL_ENA  = 4'd14;
  localparam logic [2:0] MODE_IN  = 3'b011;
  localparam logic [2:0] MODE_OUT = 3'b111;
  localparam int         FBIT     = 2;
  localparam logic [3:0] NBITS    = 4'd8;

  logic [2:0] sclk_q;
  logic [1:0] din_q;
  logic [7:0] sr_q, mode_q, orb_q, dir_q;
  logic [6:0] ier_q;
  logic       flag_q, so_q;
  logic [3:0] cnt_q;

  logic rise, fall, sr_acc, m_in, m_out, step, done;
  assign rise   = sclk_q[1] & ~sclk_q[2];
  assign fall   = ~sclk_q[1] & sclk_q[2];
  assign sr_acc = (rd_en | wr_en) && reg_sel == SEL_SR;
  assign m_in   = mode_q[4:2] == MODE_IN;
  assign m_out  = mode_q[4:2] == MODE_OUT;
  assign step   = !sr_acc && cnt_q < NBITS && ((m_in && rise) || (m_out && fall));
  assign done   = step && cnt_q == NBITS - 4'd1;

  assign irq     = flag_q & ier_q[FBIT];
  assign ser_out = so_q;
  assign pb_out  = orb_q;
  assign pb_dir  = dir_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      din_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], ext_sclk};
      din_q  <= {din_q[0], ser_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      orb_q  <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      ier_q  <= '0;
    end else if (wr_en) begin
      case (reg_sel)
        SEL_PB:   orb_q  <= wr_data;
        SEL_DIR:  dir_q  <= wr_data;
        SEL_MODE: mode_q <= wr_data;
        SEL_ENA:  ier_q  <= wr_data[7] ? (ier_q | wr_data[6:0]) : (ier_q & ~wr_data[6:0]);
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      so_q  <= 1'b0;
    end else if (sr_acc) begin
      cnt_q <= '0;
      if (wr_en) sr_q <= wr_data;
    end else if (step) begin
      cnt_q <= cnt_q + 4'd1;
      if (m_out) begin
        so_q <= sr_q[7];
        sr_q <= {sr_q[6:0], sr_q[7]};
      end else begin
        sr_q <= {sr_q[6:0], din_q[1]};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= 1'b0;
    else if (sr_acc) flag_q <= 1'b0;
    else if (done) flag_q <= 1'b1;
    else if (wr_en && reg_sel == SEL_FLG && wr_data[FBIT]) flag_q <= 1'b0;

  always_comb begin
    case (reg_sel)
      SEL_PB:   rd_data = (orb_q & dir_q) | (pb_in & ~dir_q);
      SEL_DIR:  rd_data = dir_q;
      SEL_SR:   rd_data = sr_q;
      SEL_MODE: rd_data = mode_q;
      SEL_FLG:  rd_data = {irq, 4'b0000, flag_q, 2'b00};
      SEL_ENA:  rd_data = {1'b0, ier_q};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sr_periph_chk.sv
module sr_periph_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] reg_sel,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic [7:0] pb_out,
  input logic [6:0] ier_q,
  input logic       flag_q,
  input logic [3:0] cnt_q,
  input logic [7:0] sr_q
);
  AST_SR_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && reg_sel == 4'd10) |=> !flag_q && !irq); // R6
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 4'd8); // R5
  AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 4'd8 && !(wr_en && reg_sel == 4'd10)) |=> $stable(sr_q)); // R5
  AST_ENA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 4'd14 && wr_data[7] && wr_data[2]) |=> ier_q[2]); // R7
  AST_ENA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 4'd14 && !wr_data[7] && wr_data[2]) |=> !ier_q[2]); // R7
  AST_FLAG_READ_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == 4'd13) |-> rd_data[7] == irq); // R8
  AST_FLAG_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 4'd13 && wr_data[2] && cnt_q == 4'd8) |=> !flag_q); // R9
  AST_PORT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 4'd0) |=> pb_out == $past(wr_data)); // R10
endmodule

bind sr_periph sr_periph_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .pb_out(pb_out),
  .ier_q(ier_q), .flag_q(flag_q), .cnt_q(cnt_q), .sr_q(sr_q)
);

// File: tb/tb_sr_periph.sv
`timescale 1ns/1ps
module tb_sr_periph;
  logic       clk = 0, rst_n = 0;
  logic [3:0] reg_sel = 0;
  logic       rd_en = 0, wr_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       ext_sclk = 0, ser_in = 0, ser_out;
  logic [7:0] pb_in = 0, pb_out, pb_dir;
  logic       irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sr_periph dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ext_sclk(ext_sclk), .ser_in(ser_in),
    .ser_out(ser_out), .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir), .irq(irq));

  logic [7:0] m_sr, m_mode, m_orb, m_dir;
  logic [6:0] m_ier;
  bit m_flag, m_so;
  int m_cnt;
  bit hc[$] = '{0, 0, 0};
  bit hd[$] = '{0, 0, 0};

  task automatic model_step();
    bit acc, rise, fall, stp;
    if (!rst_n) begin
      m_sr = 0; m_mode = 0; m_orb = 0; m_dir = 0; m_ier = 0;
      m_flag = 0; m_so = 0; m_cnt = 0; hc = '{0, 0, 0}; hd = '{0, 0, 0};
      return;
    end
    acc  = (rd_en || wr_en) && reg_sel == 10;
    rise = hc[1] && !hc[2];
    fall = !hc[1] && hc[2];
    stp  = !acc && m_cnt < 8 && ((m_mode[4:2] == 3'b011 && rise) || (m_mode[4:2] == 3'b111 && fall));
    if (wr_en && reg_sel == 13 && wr_data[2]) m_flag = 0;
    if (acc) begin
      m_cnt = 0; m_flag = 0;
      if (wr_en) m_sr = wr_data;
    end else if (stp) begin
      if (m_mode[4:2] == 3'b111) begin m_so = m_sr[7]; m_sr = {m_sr[6:0], m_sr[7]}; end
      else m_sr = {m_sr[6:0], hd[1]};
      m_cnt++;
      if (m_cnt == 8) m_flag = 1;
    end
    if (wr_en) begin
      if (reg_sel == 0) m_orb = wr_data;
      if (reg_sel == 2) m_dir = wr_data;
      if (reg_sel == 11) m_mode = wr_data;
      if (reg_sel == 14) m_ier = wr_data[7] ? (m_ier | wr_data[6:0]) : (m_ier & ~wr_data[6:0]);
    end
    hc.push_front(ext_sclk); void'(hc.pop_back());
    hd.push_front(ser_in);   void'(hd.pop_back());
  endtask

  always begin
    @(posedge clk);
    model_step();
    #1;
    checks++;
    if (irq !== (m_flag & m_ier[2])) begin errors++; $display("FAIL R8 irq act=%0b exp=%0b", irq, m_flag & m_ier[2]); end
    checks++;
    if (ser_out !== m_so) begin errors++; $display("FAIL R4 ser_out act=%0b exp=%0b", ser_out, m_so); end
    checks++;
    if (pb_out !== m_orb || pb_dir !== m_dir) begin
      errors++; $display("FAIL R10 port act=%h/%h exp=%h/%h", pb_out, pb_dir, m_orb, m_dir);
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] s, input logic [7:0] exp, input string tag);
    @(negedge clk); reg_sel = s; rd_en = 1; #1;
    chk(tag, rd_data, exp);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(input bit d);
    @(negedge clk); ser_in = d; ext_sclk = 1;
    repeat (4) @(negedge clk);
    ext_sclk = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse(b[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 ser_out", {7'b0, ser_out}, 8'h00);
    chk("R1 pb_dir", pb_dir, 8'h00);
    rd(4'd10, 8'h00, "R1 shift reg");
    rd(4'd11, 8'h00, "R1 mode");
    rd(4'd14, 8'h00, "R1 enable");
    rd(4'd13, 8'h00, "R1 flags");

    wr(4'd2, 8'hF0); wr(4'd0, 8'hA5); pb_in = 8'h3C;
    rd(4'd0, 8'hAC, "R10 port read mix");
    chk("R10 pb_out", pb_out, 8'hA5);
    chk("R10 pb_dir", pb_dir, 8'hF0);

    wr(4'd5, 8'hFF);
    rd(4'd5, 8'h00, "R2 unused slot");
    rd(4'd11, 8'h00, "R2 mode untouched");
    rd(4'd2, 8'hF0, "R2 direction slot");

    wr(4'd14, 8'h84); rd(4'd14, 8'h04, "R7 set bit2");
    wr(4'd14, 8'h83); rd(4'd14, 8'h07, "R7 set bits1-0 keep2");
    wr(4'd14, 8'h03); rd(4'd14, 8'h04, "R7 clear bits1-0");

    wr(4'd11, 8'h0C); wr(4'd10, 8'h00);
    send_byte(8'hB6);
    chk("R3 irq after 8 edges", {7'b0, irq}, 8'h01);
    rd(4'd13, 8'h84, "R8 flag read");
    rd(4'd10, 8'hB6, "R3 received byte");
    chk("R6 irq cleared by read", {7'b0, irq}, 8'h00);

    send_byte(8'h5A); pulse(1); pulse(1);
    rd(4'd10, 8'h5A, "R5 no shift after full");

    wr(4'd11, 8'h00); wr(4'd10, 8'h11);
    send_byte(8'hFF);
    rd(4'd13, 8'h00, "R5 idle mode no flag");
    rd(4'd10, 8'h11, "R5 idle mode no shift");

    wr(4'd11, 8'h1C); wr(4'd10, 8'hC3);
    for (int i = 0; i < 8; i++) begin
      pulse(0);
      chk("R4 ser_out bit", {7'b0, ser_out}, {7'b0, 8'hC3 >> (7 - i) & 8'h01});
    end
    chk("R4 irq after 8 falls", {7'b0, irq}, 8'h01);
    rd(4'd10, 8'hC3, "R4 rotated back");

    wr(4'd11, 8'h0C); wr(4'd10, 8'h00);
    send_byte(8'h01);
    chk("R9 irq before clear", {7'b0, irq}, 8'h01);
    wr(4'd13, 8'h7F);
    chk("R9 irq after clear", {7'b0, irq}, 8'h00);
    rd(4'd13, 8'h00, "R9 flags cleared");
    rd(4'd10, 8'h01, "R9 shift reg kept");

    send_byte(8'h02);
    wr(4'd14, 8'h04);
    chk("R8 masked irq", {7'b0, irq}, 8'h00);
    rd(4'd13, 8'h04, "R8 masked flag read");
    wr(4'd14, 8'h84);
    chk("R8 unmasked irq", {7'b0, irq}, 8'h01);
    rd(4'd13, 8'h84, "R8 unmasked flag read");

    wr(4'd10, 8'h00);
    repeat (4) pulse(1);
    wr(4'd10, 8'h00);
    repeat (4) pulse(1);
    chk("R6 count restarted", {7'b0, irq}, 8'h00);
    repeat (4) pulse(1);
    chk("R6 flag after 8 new", {7'b0, irq}, 8'h01);
    rd(4'd10, 8'hFF, "R6 byte after restart");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule